// File: doc/BRIEF.md
# Store Buffer with Youngest-Match Forwarding

This block holds committed stores of one core between the execution pipeline and the first-level data cache. Each accepted store carries a word address, a data word and byte enables. The oldest held store is offered to the cache through a request/acknowledge pair. The next store is offered only after the current one is acknowledged, so stores reach the cache one at a time and in the order they were accepted. The block sends no coherence traffic of its own and is never snooped. It talks only to its own core and its own cache.

Loads pass through the same block. A load first searches the held stores by word address. When the youngest matching store writes every byte of the word, its data is returned directly. When the youngest matching store writes only some of the bytes, the load waits until that store has reached the cache. A load that matches nothing goes to the cache read port at once, even if older stores to other words are still queued. Store-then-load pairs to different words can therefore reorder.

A fence input gives store-to-load ordering when software asks for it. While the fence is high and any store is still held, no load is accepted and no cache read is issued. The result is total-store-order behaviour with forwarding. The depth is a parameter and must be a power of two.

Top module: `stq_core`

## Requirements
- R1: After reset the buffer is empty. `st_ready` is 1, `sb_empty` is 1, and `cw_req` and `ld_rsp_valid` are 0.
- R2: Stores are written to the cache in the order they were accepted. `cw_req` is high whenever a store is held. `cw_addr`, `cw_data` and `cw_be` show the oldest store and stay unchanged until `cw_ack`. A later write to the same word lands after an earlier one.
- R3: When DEPTH stores are held, `st_ready` is 0 and a presented store is not taken. In the cycle after an acknowledged cache write, `st_ready` is 1 again.
- R4: A load is accepted only when `ld_valid` and `ld_ready` are both high. `ld_rsp_valid` pulses in the next cycle with the result, and at no other time. A load that hits a held store with all byte enables set (`be` = all ones) completes without a cache read.
- R5: When several held stores match a load's word address, the returned data comes from the most recently accepted one.
- R6: A load that matches no held store raises `cr_req` with `cr_addr` = `ld_addr`, whatever older stores are queued. `ld_ready` equals `cr_ack` in that cycle, and the response carries `cr_data`.
- R7: If the youngest matching store has any byte enable at 0, `ld_ready` and `cr_req` stay 0 until that store is acknowledged by the cache. The load then reads the merged word from the cache.
- R8: While `fence` is 1 and any store is held, `ld_ready` and `cr_req` are 0, even for a load that would forward. Once the buffer is empty, loads proceed.
- R9: `sb_empty` is 1 exactly when no store is held.
- R10: A store accepted in the same cycle as a load is not visible to that load. With an otherwise empty buffer, the load goes to the cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store can be taken |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| ld_valid | input | 1 | Load offered |
| ld_ready | output | 1 | Load completes this cycle |
| ld_addr | input | AW | Load word address |
| ld_rsp_valid | output | 1 | Load result valid |
| ld_rsp_data | output | DW | Load result |
| fence | input | 1 | Hold loads until the buffer is empty |
| cr_req | output | 1 | Cache read request |
| cr_addr | output | AW | Cache read word address |
| cr_ack | input | 1 | Cache read data present |
| cr_data | input | DW | Cache read data |
| cw_req | output | 1 | Cache write request (oldest store) |
| cw_addr | output | AW | Cache write word address |
| cw_data | output | DW | Cache write data |
| cw_be | output | DW/8 | Cache write byte enables |
| cw_ack | input | 1 | Cache write accepted |
| sb_empty | output | 1 | No store held |

## Verification
The bench fills the buffer with repeated word addresses while the cache holds off its acknowledge. A load can then tell youngest-match forwarding apart from oldest-match forwarding. It can also tell forwarding apart from a stale cache read. A lone partial-enable store checks the wait-then-merge path against a forward that would return unmerged data. A fenced load to a forwardable word shows whether the fence overrides forwarding. A store and a load to the same word in one cycle separate "not yet visible" from early visibility. Long mixed traffic follows, with random acknowledges, partial enables and fence pulses. In every cycle it compares the block against a queue model, which exposes drain-order and full-stall errors.

// File: rtl/stq_pkg.sv
// Shared types of the store buffer.
package stq_pkg;
    // Decision made for the load presented in the current cycle.
    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_WAIT  = 2'd1,
        LD_FWD   = 2'd2,
        LD_CACHE = 2'd3
    } ld_act_e;
endpackage

// File: rtl/stq_ring.sv
// Circular store storage with head/tail pointers and an occupancy count.
// Assumes DEPTH is a power of two, so pointer wrap is plain overflow.
// The caller guarantees push only when not full and pop only when not empty.
module stq_ring #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int BW   = DW / 8,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic [BW-1:0] push_be,
    input  logic          pop,
    output logic [AW-1:0] slot_addr [DEPTH],
    output logic [DW-1:0] slot_data [DEPTH],
    output logic [BW-1:0] slot_be   [DEPTH],
    output logic [IW-1:0] head_ptr,
    output logic [CW-1:0] occ
);
    logic [IW-1:0] tail_ptr;

    // Write the new store into the tail slot.
    always_ff @(posedge clk) begin
        if (push) begin
            slot_addr[tail_ptr] <= push_addr;
            slot_data[tail_ptr] <= push_data;
            slot_be[tail_ptr]   <= push_be;
        end
    end

    // Advance the pointers and keep the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_ptr <= '0;
            tail_ptr <= '0;
            occ      <= '0;
        end else begin
            if (push) tail_ptr <= tail_ptr + IW'(1);
            if (pop)  head_ptr <= head_ptr + IW'(1);
            occ <= occ + CW'(push) - CW'(pop);
        end
    end
endmodule

// File: rtl/stq_match.sv
// Finds the youngest live entry whose word address equals the load address.
// Also reports whether that entry writes every byte of the word.
// Assumes DEPTH is a power of two (age = slot - head, modulo DEPTH).
module stq_match #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int BW    = 4,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = IW + 1
) (
    input  logic [AW-1:0] slot_addr [DEPTH],
    input  logic [BW-1:0] slot_be   [DEPTH],
    input  logic [IW-1:0] head_ptr,
    input  logic [CW-1:0] occ,
    input  logic [AW-1:0] ld_addr,
    output logic          hit,
    output logic          hit_full,
    output logic [IW-1:0] hit_slot
);
    logic [DEPTH-1:0] slot_eq;
    logic [IW-1:0]    scan_slot;

    // Per-slot liveness and address compare.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        logic [IW-1:0] age;
        assign age        = IW'(i) - head_ptr;
        assign slot_eq[i] = ({1'b0, age} < occ) && (slot_addr[i] == ld_addr);
    end

    // Walk from oldest to youngest so that the last match found wins.
    always_comb begin
        hit       = 1'b0;
        hit_slot  = '0;
        scan_slot = '0;
        for (int k = 0; k < DEPTH; k++) begin
            scan_slot = head_ptr + IW'(k);
            if (slot_eq[scan_slot]) begin
                hit      = 1'b1;
                hit_slot = scan_slot;
            end
        end
        hit_full = &slot_be[hit_slot];
    end
endmodule

// File: rtl/stq_load_ctl.sv
// Load decision and response register.
// The fence blocks loads while stores are held. A full-word hit forwards.
// A partial hit waits. A miss reads the cache and completes on cr_ack.
// The response appears one cycle after acceptance.
module stq_load_ctl
    import stq_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    input  logic          fence,
    input  logic          buf_empty,
    input  logic          hit,
    input  logic          hit_full,
    input  logic [DW-1:0] fwd_data,
    input  logic          cr_ack,
    input  logic [DW-1:0] cr_data,
    output logic          ld_ready,
    output logic          cr_req,
    output logic [AW-1:0] cr_addr,
    output logic          ld_rsp_valid,
    output logic [DW-1:0] ld_rsp_data
);
    ld_act_e act;

    // Choose what the presented load does this cycle.
    always_comb begin
        act = LD_IDLE;
        if (ld_valid) begin
            if (fence && !buf_empty) act = LD_WAIT;
            else if (hit)            act = hit_full ? LD_FWD : LD_WAIT;
            else                     act = LD_CACHE;
        end
        cr_req   = (act == LD_CACHE);
        cr_addr  = ld_addr;
        ld_ready = (act == LD_FWD) || ((act == LD_CACHE) && cr_ack);
    end

    // Register the result of an accepted load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_rsp_valid <= 1'b0;
            ld_rsp_data  <= '0;
        end else begin
            ld_rsp_valid <= ld_ready;
            if (ld_ready) ld_rsp_data <= (act == LD_FWD) ? fwd_data : cr_data;
        end
    end
endmodule

// File: rtl/stq_core.sv
// Per-core store buffer: FIFO drain of committed stores to the data cache.
// Forwards from the youngest matching store and supports a store-load fence.
// Assumes word-aligned accesses and a DEPTH that is a power of two.
module stq_core #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int BW   = DW / 8,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    output logic          st_ready,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic [BW-1:0] st_be,
    input  logic          ld_valid,
    output logic          ld_ready,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_rsp_valid,
    output logic [DW-1:0] ld_rsp_data,
    input  logic          fence,
    output logic          cr_req,
    output logic [AW-1:0] cr_addr,
    input  logic          cr_ack,
    input  logic [DW-1:0] cr_data,
    output logic          cw_req,
    output logic [AW-1:0] cw_addr,
    output logic [DW-1:0] cw_data,
    output logic [BW-1:0] cw_be,
    input  logic          cw_ack,
    output logic          sb_empty
);
    logic [AW-1:0] slot_addr [DEPTH];
    logic [DW-1:0] slot_data [DEPTH];
    logic [BW-1:0] slot_be   [DEPTH];
    logic [IW-1:0] head_ptr;
    logic [CW-1:0] occ;
    logic          push, pop, hit, hit_full;
    logic [IW-1:0] hit_slot;

    // Edge flags and handshakes derived from occupancy.
    always_comb begin
        sb_empty = (occ == '0);
        st_ready = (occ != CW'(DEPTH));
        cw_req   = !sb_empty;
        push     = st_valid && st_ready;
        pop      = cw_req && cw_ack;
        cw_addr  = slot_addr[head_ptr];
        cw_data  = slot_data[head_ptr];
        cw_be    = slot_be[head_ptr];
    end

    stq_ring #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_ring (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_addr(st_addr), .push_data(st_data), .push_be(st_be),
        .pop(pop),
        .slot_addr(slot_addr), .slot_data(slot_data), .slot_be(slot_be),
        .head_ptr(head_ptr), .occ(occ)
    );

    stq_match #(.DEPTH(DEPTH), .AW(AW), .BW(BW)) u_match (
        .slot_addr(slot_addr), .slot_be(slot_be),
        .head_ptr(head_ptr), .occ(occ), .ld_addr(ld_addr),
        .hit(hit), .hit_full(hit_full), .hit_slot(hit_slot)
    );

    stq_load_ctl #(.AW(AW), .DW(DW)) u_load (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .fence(fence),
        .buf_empty(sb_empty), .hit(hit), .hit_full(hit_full),
        .fwd_data(slot_data[hit_slot]),
        .cr_ack(cr_ack), .cr_data(cr_data),
        .ld_ready(ld_ready), .cr_req(cr_req), .cr_addr(cr_addr),
        .ld_rsp_valid(ld_rsp_valid), .ld_rsp_data(ld_rsp_data)
    );
endmodule

// File: rtl/stq_core_chk.sv
// Property checker for stq_core, attached by bind.
// Keeps its own occupancy count from the port handshakes.
module stq_core_chk #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int BW   = DW / 8,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          st_valid,
    input logic          st_ready,
    input logic          ld_valid,
    input logic          ld_ready,
    input logic          ld_rsp_valid,
    input logic          fence,
    input logic          cr_req,
    input logic          cw_req,
    input logic          cw_ack,
    input logic [AW-1:0] cw_addr,
    input logic [DW-1:0] cw_data,
    input logic [BW-1:0] cw_be,
    input logic          sb_empty
);
    logic [CW-1:0] seen_occ;

    // Count stores held, as seen at the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_occ <= '0;
        else seen_occ <= seen_occ + CW'(st_valid && st_ready) - CW'(cw_req && cw_ack);
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        seen_occ <= CW'(DEPTH)); // R3
    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_occ == CW'(DEPTH)) |-> !st_ready); // R3
    AST_EMPTY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        sb_empty == (seen_occ == '0)); // R9
    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_req && !cw_ack) |=> (cw_req && $stable(cw_addr) && $stable(cw_data) && $stable(cw_be))); // R2
    AST_FENCE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fence && !sb_empty) |-> (!ld_ready && !cr_req)); // R8
    AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_ready) |=> ld_rsp_valid); // R4
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_valid && ld_ready) |=> !ld_rsp_valid); // R4
endmodule

bind stq_core stq_core_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (.*);

// File: tb/stq_core_bench.sv
// Bench for stq_core: a queue reference model compared every cycle, plus directed cases.
module stq_core_bench;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 8;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] d;
        logic [3:0]  b;
    } ent_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 0, ld_valid = 0, fence = 0, cr_ack = 0, cw_ack = 0;
    logic [31:0] st_addr = 0, st_data = 0, ld_addr = 0, cr_data = 0;
    logic [3:0]  st_be = 0;
    logic        st_ready, ld_ready, ld_rsp_valid, cr_req, cw_req, sb_empty;
    logic [31:0] ld_rsp_data, cr_addr, cw_addr, cw_data;
    logic [3:0]  cw_be;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    ent_t        q[$];
    logic [31:0] cmem [int unsigned];
    logic        exp_rsp_v = 0;
    logic [31:0] exp_rsp_d = 0;
    string       exp_rsp_tag = "R4";

    stq_core #(.DEPTH(DEPTH), .AW(32), .DW(32)) u_stq_core (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
        .ld_rsp_valid(ld_rsp_valid), .ld_rsp_data(ld_rsp_data),
        .fence(fence),
        .cr_req(cr_req), .cr_addr(cr_addr), .cr_ack(cr_ack), .cr_data(cr_data),
        .cw_req(cw_req), .cw_addr(cw_addr), .cw_data(cw_data), .cw_be(cw_be), .cw_ack(cw_ack),
        .sb_empty(sb_empty)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return cmem.exists(a) ? cmem[a] : 32'h0;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic settle();
        cr_data = rd(ld_addr);
        #1;
    endtask

    // One cycle: compare against the model, then advance model and cache.
    task automatic tick();
        int   j;
        bit   blk, fwd, part, e_cr, e_ldr, st_ok, nv;
        logic [31:0] nd;
        string tg;
        settle();
        j = -1;
        for (int k = 0; k < q.size(); k++) if (q[k].a == ld_addr) j = k;
        blk   = fence && (q.size() != 0);
        fwd   = 0; part = 0; e_cr = 0; e_ldr = 0;
        if (ld_valid && !blk) begin
            if (j >= 0) begin
                if (q[j].b == 4'hF) begin fwd = 1; e_ldr = 1; end
                else part = 1;
            end else begin
                e_cr = 1; e_ldr = cr_ack;
            end
        end
        tg = blk ? "R8" : (part ? "R7" : (fwd ? "R4" : "R6"));
        chk(ld_rsp_valid == exp_rsp_v, "R4 rsp_valid", 32'(ld_rsp_valid), 32'(exp_rsp_v));
        if (exp_rsp_v) chk(ld_rsp_data == exp_rsp_d, exp_rsp_tag, ld_rsp_data, exp_rsp_d);
        chk(st_ready == (q.size() < DEPTH), "R3 st_ready", 32'(st_ready), 32'(q.size() < DEPTH));
        chk(sb_empty == (q.size() == 0), "R9 sb_empty", 32'(sb_empty), 32'(q.size() == 0));
        chk(cw_req == (q.size() != 0), "R2 cw_req", 32'(cw_req), 32'(q.size() != 0));
        if (q.size() != 0) begin
            chk(cw_addr == q[0].a, "R2 cw_addr", cw_addr, q[0].a);
            chk(cw_data == q[0].d, "R2 cw_data", cw_data, q[0].d);
            chk(cw_be == q[0].b, "R2 cw_be", 32'(cw_be), 32'(q[0].b));
        end
        chk(cr_req == e_cr, tg, 32'(cr_req), 32'(e_cr));
        if (e_cr) chk(cr_addr == ld_addr, "R6 cr_addr", cr_addr, ld_addr);
        chk(ld_ready == e_ldr, tg, 32'(ld_ready), 32'(e_ldr));
        nv = ld_valid && e_ldr;
        nd = fwd ? q[j].d : cr_data;
        st_ok = st_valid && (q.size() < DEPTH);
        if (cw_req && cw_ack) begin
            logic [31:0] m;
            m = rd(cw_addr);
            for (int b = 0; b < 4; b++) if (cw_be[b]) m[8*b +: 8] = cw_data[8*b +: 8];
            cmem[cw_addr] = m;
        end
        if (cw_ack && q.size() != 0) void'(q.pop_front());
        if (st_ok) q.push_back('{a: st_addr, d: st_data, b: st_be});
        exp_rsp_v   = nv;
        exp_rsp_d   = nd;
        exp_rsp_tag = fwd ? "R5 fwd data" : "R6 cache data";
        @(negedge clk);
    endtask

    task automatic quiet();
        st_valid = 0; ld_valid = 0; fence = 0; cr_ack = 0; cw_ack = 0;
    endtask

    task automatic drain_all();
        quiet();
        cw_ack = 1;
        while (q.size() != 0) tick();
        cw_ack = 0;
        tick();
    endtask

    // Watchdog: a hung run is a failure.
    initial begin
        #(PERIOD * 150000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 / R9: reset state
        chk(st_ready == 1, "R1 st_ready", 32'(st_ready), 1);
        chk(sb_empty == 1, "R9 sb_empty after reset", 32'(sb_empty), 1);
        chk(cw_req == 0, "R1 cw_req", 32'(cw_req), 0);
        chk(ld_rsp_valid == 0, "R1 ld_rsp_valid", 32'(ld_rsp_valid), 0);

        // Fill the buffer with repeated word addresses, cache holding writes.
        cmem[32'h99] = 32'h5A5A_5A5A;
        for (int i = 0; i < DEPTH; i++) begin
            st_valid = 1; st_addr = 32'h40 + 32'(i % 3); st_data = 32'hD000 + 32'(i); st_be = 4'hF;
            tick();
        end
        st_valid = 0;
        // R3: full stalls the store input
        st_valid = 1; st_addr = 32'h77; st_data = 32'h7777; st_be = 4'hF;
        settle();
        chk(st_ready == 0, "R3 full stall", 32'(st_ready), 0);
        tick();
        st_valid = 0;
        // R4/R5: forward from youngest of three matches, no cache read
        ld_valid = 1; ld_addr = 32'h40;
        settle();
        chk(cr_req == 0, "R4 no cache read on hit", 32'(cr_req), 0);
        tick();
        ld_valid = 0;
        chk(ld_rsp_data == 32'hD006, "R5 youngest match", ld_rsp_data, 32'hD006);
        // R6: unmatched load bypasses queued stores
        ld_valid = 1; ld_addr = 32'h99; cr_ack = 1;
        settle();
        chk(cr_req == 1, "R6 bypass read", 32'(cr_req), 1);
        tick();
        quiet();
        chk(ld_rsp_data == 32'h5A5A_5A5A, "R6 bypass data", ld_rsp_data, 32'h5A5A_5A5A);
        // R3: one drain frees a slot next cycle
        cw_ack = 1; tick(); cw_ack = 0;
        st_valid = 1; st_addr = 32'h77; st_data = 32'h7777; st_be = 4'hF;
        settle();
        chk(st_ready == 1, "R3 slot freed", 32'(st_ready), 1);
        tick();
        drain_all();
        // R2: later store to the same word landed last
        ld_valid = 1; ld_addr = 32'h40; cr_ack = 1;
        tick();
        quiet();
        chk(ld_rsp_data == 32'hD006, "R2 in-order drain", ld_rsp_data, 32'hD006);

        // R7: partial store makes the load wait, then the merged word is read
        cmem[32'h20] = 32'hAABB_CCDD;
        st_valid = 1; st_addr = 32'h20; st_data = 32'h1122_3344; st_be = 4'b0011;
        tick();
        st_valid = 0;
        ld_valid = 1; ld_addr = 32'h20; cr_ack = 1;
        settle();
        chk(ld_ready == 0, "R7 partial wait", 32'(ld_ready), 0);
        chk(cr_req == 0, "R7 partial no read", 32'(cr_req), 0);
        repeat (3) tick();
        cw_ack = 1; tick(); cw_ack = 0;
        tick();
        quiet();
        chk(ld_rsp_data == 32'hAABB_3344, "R7 merged data", ld_rsp_data, 32'hAABB_3344);

        // R8: fence blocks even a forwardable load until empty
        st_valid = 1; st_addr = 32'h30; st_data = 32'hF00D; st_be = 4'hF;
        tick();
        st_valid = 0;
        fence = 1; ld_valid = 1; ld_addr = 32'h30; cr_ack = 1;
        settle();
        chk(ld_ready == 0, "R8 fence hold", 32'(ld_ready), 0);
        repeat (2) tick();
        cw_ack = 1; tick(); cw_ack = 0;
        settle();
        chk(ld_ready == 1, "R8 fence released", 32'(ld_ready), 1);
        tick();
        quiet();
        chk(ld_rsp_data == 32'hF00D, "R8 data after fence", ld_rsp_data, 32'hF00D);

        // R10: same-cycle store is not seen by the load
        st_valid = 1; st_addr = 32'h50; st_data = 32'h1234; st_be = 4'hF;
        ld_valid = 1; ld_addr = 32'h50; cr_ack = 1;
        settle();
        chk(cr_req == 1, "R10 same-cycle store invisible", 32'(cr_req), 1);
        tick();
        quiet();
        chk(ld_rsp_data == 32'h0, "R10 old data", ld_rsp_data, 32'h0);
        drain_all();

        // Mixed traffic against the model
        for (int n = 0; n < 3000; n++) begin
            st_valid = 1'($urandom % 2);
            st_addr  = 32'h60 + ($urandom % 4);
            st_data  = $urandom;
            st_be    = ($urandom % 3 == 0) ? 4'($urandom) : 4'hF;
            ld_valid = 1'($urandom % 2);
            ld_addr  = 32'h60 + ($urandom % 5);
            fence    = ($urandom % 8 == 0);
            cw_ack   = 1'($urandom % 2);
            cr_ack   = 1'($urandom % 2);
            tick();
        end
        drain_all();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule